// File: doc/BRIEF.md
# DMA Peripheral Handshake Burst Controller

This block is the controller end of one DMA channel's hardware handshake with a FIFO-based peripheral. The peripheral signals that it wants service by pulling an active-low request line low. The controller brings that line into the bus clock domain through a chain of flip-flops and acts only on its falling edge. Each accepted edge starts one burst of data items on a simple strobe interface: `xfer_req` with `xfer_ack` per item. The number of items in the burst is taken out of a block transfer count that is loaded while the channel is disabled. When the last item of a burst is handed over, the controller pulses an acknowledge back to the peripheral. When the block count reaches zero, it raises a done flag and ignores all further requests until the channel is disabled and enabled again.

The burst length comes from one of two settings, one for a source-side peripheral and one for a destination-side peripheral, picked by a direction input. If the count left is smaller than the burst length, the final burst is cut short to that count. The block also holds the peripheral-side request generator, which compares a FIFO fill level with a watermark. For a source FIFO it pulls its request low while the level is above the watermark. For a destination FIFO it pulls its request low while the level is below the watermark.

Top module: `dma_hs_burst_ctrl`

## Requirements
- R1: The request line passes through SYNC_STAGES (default 2) flip-flops and is acted on only at a high-to-low transition. Holding the line low starts no further burst.
- R2: Each accepted falling edge produces exactly one burst. A burst has the expected number of item handshakes, where a handshake is a clock edge with `xfer_req` and `xfer_ack` both high.
- R3: The burst length is `cfg_src_len` when `cfg_is_dst` is 0 and `cfg_dst_len` when it is 1. Both settings are plain item counts, and a setting of 0 is treated as 1 item.
- R4: At the end of each burst, `rem_count` drops by that burst's item count. A burst is truncated to `rem_count` when `rem_count` is smaller than the burst length.
- R5: `dma_ack` is high for exactly one cycle after the last handshake of each burst, once per burst.
- R6: `xfer_last` is high during the last item of a burst and low during every other item.
- R7: `blk_done` rises when the remaining count is zero while the channel is enabled. This includes a block count of zero loaded at enable. After that, falling edges start no burst until `chan_en` has been low and then high again.
- R8: A falling edge that arrives while a burst is in progress is ignored and starts no extra burst.
- R9: While `chan_en` is low, any burst is abandoned, `xfer_req` and `blk_done` are low, and `rem_count` follows `cfg_block_len`.
- R10: In source mode (`cfg_is_dst` = 0), `per_req_n` is low exactly when `per_fifo_level` > `per_fifo_wm`, one clock after the inputs are presented.
- R11: In destination mode (`cfg_is_dst` = 1), `per_req_n` is low exactly when `per_fifo_level` < `per_fifo_wm`, one clock after the inputs are presented.
- R12: After reset, `xfer_req`, `xfer_last`, `dma_ack` and `blk_done` are low, `per_req_n` is high, and `rem_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low reloads the count and clears done |
| cfg_is_dst | input | 1 | 0: source-side peripheral, 1: destination-side peripheral |
| cfg_src_len | input | LEN_W | Source-side burst length in items |
| cfg_dst_len | input | LEN_W | Destination-side burst length in items |
| cfg_block_len | input | CNT_W | Block transfer count in items |
| hs_req_n | input | 1 | Active-low request from the peripheral, asynchronous |
| dma_ack | output | 1 | One-cycle burst-complete acknowledge to the peripheral |
| xfer_req | output | 1 | Item transfer request to the bus side |
| xfer_last | output | 1 | Marks the last item of the current burst |
| xfer_ack | input | 1 | Bus side accepts the current item |
| rem_count | output | CNT_W | Items left in the block |
| blk_done | output | 1 | Block complete |
| per_fifo_level | input | LVL_W | Peripheral FIFO fill level |
| per_fifo_wm | input | LVL_W | Peripheral FIFO watermark |
| per_req_n | output | 1 | Generated active-low request from the watermark compare |

## Verification
A wrong burst size or a missed count update shows up in the item handshakes of the burst itself. It is then visible in `rem_count` within one cycle of `dma_ack`, so every burst is compared both by its item total and by the count left afterwards. A bad edge detector or a stale busy state shows up as an extra burst or a missing burst a few cycles after the request line moves. The bench therefore holds the line low, toggles it during stalled bursts, and checks that no further handshakes follow. A corrupted done or reload state shows up on `blk_done` and `rem_count` within two cycles of `chan_en` changing.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

   typedef enum logic {
      HS_IDLE  = 1'b0,
      HS_BURST = 1'b1
   } hs_state_t;

   typedef enum logic {
      SIDE_SRC = 1'b0,
      SIDE_DST = 1'b1
   } hs_side_t;

endpackage

// File: rtl/hs_req_sync.sv
module hs_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n_async,
   output logic req_fall
);

   initial begin
      if (STAGES < 2) $error("hs_req_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b1;
      else        sync_q[0] <= req_n_async;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[g] <= 1'b1;
         else        sync_q[g] <= sync_q[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign req_fall = prev_q & ~sync_q[STAGES-1];

   // R1: an edge lasts a single cycle, so a held level cannot repeat it
   a_r1_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      req_fall |=> !req_fall);

endmodule

// File: rtl/hs_wm_reqgen.sv
module hs_wm_reqgen #(
   parameter int LVL_W   = 6,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             is_dst,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] wm,
   output logic             req_n
);

   initial begin
      if (LVL_W < 1) $error("hs_wm_reqgen: LVL_W must be positive");
   end

   logic want;

   always_comb begin
      if (is_dst == dma_hs_pkg::SIDE_DST) want = (level < wm);
      else                                want = (level > wm);
   end

   if (REG_OUT) begin : g_reg
      logic req_n_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_n_q <= 1'b1;
         else        req_n_q <= ~want;
      end
      assign req_n = req_n_q;

      // R10: a source FIFO at or below the watermark never requests
      a_r10_src_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(is_dst) == 1'b0 && $past(level) <= $past(wm)) |-> req_n);
      // R11: a destination FIFO at or above the watermark never requests
      a_r11_dst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(is_dst) == 1'b1 && $past(level) >= $past(wm)) |-> req_n);
   end else begin : g_comb
      assign req_n = ~want;
   end

endmodule

// File: rtl/hs_burst_engine.sv
module hs_burst_engine
   import dma_hs_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             req_fall,
   input  logic [LEN_W-1:0] burst_len,
   input  logic [CNT_W-1:0] block_len,
   output logic             xfer_req,
   output logic             xfer_last,
   input  logic             xfer_ack,
   output logic             dma_ack,
   output logic [CNT_W-1:0] rem_count,
   output logic             blk_done
);

   initial begin
      if (LEN_W < 1)     $error("hs_burst_engine: LEN_W must be positive");
      if (CNT_W < LEN_W) $error("hs_burst_engine: CNT_W must be at least LEN_W");
   end

   localparam int PAD_W = CNT_W - LEN_W;

   hs_state_t        state_q;
   logic [LEN_W-1:0] beat_q;
   logic [LEN_W-1:0] size_q;
   logic [CNT_W-1:0] rem_q;
   logic             done_q;
   logic             ack_q;

   logic [LEN_W-1:0] eff_len;
   logic [CNT_W-1:0] eff_wide;
   logic [CNT_W-1:0] next_size;
   logic             at_last;
   logic             start;

   assign eff_len   = (burst_len == '0) ? LEN_W'(1) : burst_len;
   assign eff_wide  = {{PAD_W{1'b0}}, eff_len};
   assign next_size = (rem_q < eff_wide) ? rem_q : eff_wide;
   assign at_last   = (beat_q == size_q - LEN_W'(1));
   assign start     = chan_en && !done_q && (rem_q != '0) && req_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= HS_IDLE;
         beat_q  <= '0;
         size_q  <= '0;
         rem_q   <= '0;
         done_q  <= 1'b0;
         ack_q   <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         if (!chan_en) begin
            state_q <= HS_IDLE;
            rem_q   <= block_len;
            done_q  <= 1'b0;
            beat_q  <= '0;
         end else begin
            unique case (state_q)
               HS_IDLE: begin
                  if (rem_q == '0) begin
                     done_q <= 1'b1;
                  end else if (start) begin
                     size_q  <= next_size[LEN_W-1:0];
                     beat_q  <= '0;
                     state_q <= HS_BURST;
                  end
               end
               HS_BURST: begin
                  if (xfer_ack) begin
                     if (at_last) begin
                        rem_q   <= rem_q - {{PAD_W{1'b0}}, size_q};
                        ack_q   <= 1'b1;
                        state_q <= HS_IDLE;
                     end else begin
                        beat_q <= beat_q + LEN_W'(1);
                     end
                  end
               end
               default: state_q <= HS_IDLE;
            endcase
         end
      end
   end

   assign xfer_req  = (state_q == HS_BURST);
   assign xfer_last = xfer_req && at_last;
   assign dma_ack   = ack_q;
   assign rem_count = rem_q;
   assign blk_done  = done_q;

   // R5: the burst acknowledge never stretches past one cycle
   a_r5_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dma_ack |=> !dma_ack);
   // R6: the last-item marker only appears during a transfer
   a_r6_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_last |-> xfer_req);
   // R7: a finished block never requests more items
   a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      blk_done |-> !xfer_req);
   // R4: the remaining count only falls while the channel stays enabled
   a_r4_rem_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(chan_en) && chan_en) |-> rem_count <= $past(rem_count));
   // R9: disabling the channel ends any transfer at the next edge
   a_r9_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !xfer_req);
   // R8: a burst in progress is not restarted from its first item
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_ack && chan_en) |=> (xfer_req && $stable(xfer_last)));

endmodule

// File: rtl/dma_hs_burst_ctrl.sv
module dma_hs_burst_ctrl
   import dma_hs_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int LEN_W       = 4,
   parameter int LVL_W       = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit WM_REG_OUT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             cfg_is_dst,
   input  logic [LEN_W-1:0] cfg_src_len,
   input  logic [LEN_W-1:0] cfg_dst_len,
   input  logic [CNT_W-1:0] cfg_block_len,
   input  logic             hs_req_n,
   output logic             dma_ack,
   output logic             xfer_req,
   output logic             xfer_last,
   input  logic             xfer_ack,
   output logic [CNT_W-1:0] rem_count,
   output logic             blk_done,
   input  logic [LVL_W-1:0] per_fifo_level,
   input  logic [LVL_W-1:0] per_fifo_wm,
   output logic             per_req_n
);

   logic             req_fall;
   logic [LEN_W-1:0] burst_len;

   assign burst_len = (cfg_is_dst == SIDE_DST) ? cfg_dst_len : cfg_src_len;

   hs_req_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_n_async (hs_req_n),
      .req_fall    (req_fall)
   );

   hs_burst_engine #(
      .CNT_W (CNT_W),
      .LEN_W (LEN_W)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_en   (chan_en),
      .req_fall  (req_fall),
      .burst_len (burst_len),
      .block_len (cfg_block_len),
      .xfer_req  (xfer_req),
      .xfer_last (xfer_last),
      .xfer_ack  (xfer_ack),
      .dma_ack   (dma_ack),
      .rem_count (rem_count),
      .blk_done  (blk_done)
   );

   hs_wm_reqgen #(
      .LVL_W   (LVL_W),
      .REG_OUT (WM_REG_OUT)
   ) u_reqgen (
      .clk    (clk),
      .rst_n  (rst_n),
      .is_dst (cfg_is_dst),
      .level  (per_fifo_level),
      .wm     (per_fifo_wm),
      .req_n  (per_req_n)
   );

endmodule

// File: tb/dma_hs_burst_ctrl_bench.sv
module dma_hs_burst_ctrl_bench;

   localparam int CNT_W = 12;
   localparam int LEN_W = 4;
   localparam int LVL_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             chan_en = 1'b0;
   logic             cfg_is_dst = 1'b0;
   logic [LEN_W-1:0] cfg_src_len = '0;
   logic [LEN_W-1:0] cfg_dst_len = '0;
   logic [CNT_W-1:0] cfg_block_len = '0;
   logic             hs_req_n = 1'b1;
   logic             dma_ack, xfer_req, xfer_last;
   logic             xfer_ack = 1'b0;
   logic [CNT_W-1:0] rem_count;
   logic             blk_done;
   logic [LVL_W-1:0] per_fifo_level = '0;
   logic [LVL_W-1:0] per_fifo_wm = '0;
   logic             per_req_n;

   int compared = 0, mismatched = 0;
   int cyc = 0, beats_total = 0, ack_total = 0, beat_idx = 0, exp_sz = 1, exp_rem = 0;
   bit stall = 1'b0;

   always #4 clk = ~clk;

   dma_hs_burst_ctrl u_dma_hs_burst_ctrl (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_is_dst(cfg_is_dst),
      .cfg_src_len(cfg_src_len), .cfg_dst_len(cfg_dst_len), .cfg_block_len(cfg_block_len),
      .hs_req_n(hs_req_n), .dma_ack(dma_ack), .xfer_req(xfer_req), .xfer_last(xfer_last),
      .xfer_ack(xfer_ack), .rem_count(rem_count), .blk_done(blk_done),
      .per_fifo_level(per_fifo_level), .per_fifo_wm(per_fifo_wm), .per_req_n(per_req_n)
   );

   task automatic chk(string rq, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", rq, act, exp, $time);
      end
   endtask

   function automatic int eff_len();
      int l = cfg_is_dst ? int'(cfg_dst_len) : int'(cfg_src_len);
      return (l == 0) ? 1 : l;
   endfunction

   function automatic int min2(int a, int b);
      return (a < b) ? a : b;
   endfunction

   // monitor: samples away from the rising edge, drives the bus-side accept
   always @(negedge clk) begin
      bit na;
      cyc++;
      na = stall ? 1'b0 : (($urandom % 3) != 0);
      xfer_ack = na;
      if (rst_n) begin
         if (xfer_req && na) begin
            compared++;
            if (xfer_last !== (beat_idx == exp_sz - 1)) begin
               mismatched++;
               $display("FAIL R6: xfer_last actual %0b expected %0b at item %0d",
                        xfer_last, (beat_idx == exp_sz - 1), beat_idx);
            end
            beat_idx++;
            beats_total++;
         end
         if (dma_ack) begin
            ack_total++;
            beat_idx = 0;
         end
      end
      if (cyc > 150000) begin
         mismatched++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic enable_block(int blk, int sl, int dl, bit dst);
      chan_en = 1'b0;
      cfg_block_len = CNT_W'(blk);
      cfg_src_len = LEN_W'(sl);
      cfg_dst_len = LEN_W'(dl);
      cfg_is_dst = dst;
      tick(3);
      chk("R9 reload", int'(rem_count), blk);
      chk("R9 done low", int'(blk_done), 0);
      chan_en = 1'b1;
      exp_rem = blk;
      tick(3);
   endtask

   task automatic one_burst();
      int a0 = ack_total, b0 = beats_total;
      exp_sz = min2(eff_len(), exp_rem);
      beat_idx = 0;
      hs_req_n = 1'b0;
      for (int i = 0; i < 400 && ack_total == a0; i++) tick(1);
      tick(6);                       // line held low: R1 no repeat
      hs_req_n = 1'b1;
      tick(4);
      chk("R2/R3 items in burst", beats_total - b0, exp_sz);
      chk("R5 one ack per burst", ack_total - a0, 1);
      exp_rem -= exp_sz;
      chk("R4 remaining after burst", int'(rem_count), exp_rem);
   endtask

   task automatic finish_block();
      int b0;
      while (exp_rem > 0) one_burst();
      tick(2);
      chk("R7 done raised", int'(blk_done), 1);
      b0 = beats_total;
      hs_req_n = 1'b0;
      tick(20);
      hs_req_n = 1'b1;
      tick(4);
      chk("R7 request ignored when done", beats_total - b0, 0);
      chk("R7 done held", int'(blk_done), 1);
   endtask

   initial begin
      void'($urandom(32'd1357));
      tick(3);
      chk("R12 xfer_req", int'(xfer_req), 0);
      chk("R12 xfer_last", int'(xfer_last), 0);
      chk("R12 dma_ack", int'(dma_ack), 0);
      chk("R12 blk_done", int'(blk_done), 0);
      chk("R12 per_req_n", int'(per_req_n), 1);
      chk("R12 rem_count", int'(rem_count), 0);
      rst_n = 1'b1;
      tick(2);

      // directed: exact multiple, source side
      enable_block(12, 4, 7, 1'b0);
      finish_block();
      // directed: truncated tail, destination side (R3, R4)
      enable_block(10, 2, 3, 1'b1);
      finish_block();
      // directed: zero length setting means one item (R3)
      enable_block(3, 0, 5, 1'b0);
      finish_block();
      // directed: zero block count gives done at once (R7)
      enable_block(0, 4, 4, 1'b0);
      tick(2);
      chk("R7 zero block done", int'(blk_done), 1);

      // directed: edge during a stalled burst is ignored (R8)
      begin
         int a0, b0;
         enable_block(12, 6, 2, 1'b0);
         a0 = ack_total; b0 = beats_total;
         exp_sz = 6; beat_idx = 0;
         stall = 1'b1;
         hs_req_n = 1'b0;
         for (int i = 0; i < 50 && !xfer_req; i++) tick(1);
         tick(1);
         hs_req_n = 1'b1; tick(4);
         hs_req_n = 1'b0; tick(5);
         hs_req_n = 1'b1; tick(2);
         stall = 1'b0;
         for (int i = 0; i < 200 && ack_total == a0; i++) tick(1);
         tick(20);
         chk("R8 items with mid-burst edge", beats_total - b0, 6);
         chk("R8 single ack", ack_total - a0, 1);
         chk("R8 remaining", int'(rem_count), 6);
      end

      // directed: disable during a burst (R9)
      begin
         enable_block(9, 5, 5, 1'b0);
         stall = 1'b1;
         hs_req_n = 1'b0;
         for (int i = 0; i < 50 && !xfer_req; i++) tick(1);
         chk("R2 burst started", int'(xfer_req), 1);
         chan_en = 1'b0;
         tick(2);
         chk("R9 xfer_req dropped", int'(xfer_req), 0);
         chk("R9 count reloaded", int'(rem_count), 9);
         hs_req_n = 1'b1;
         stall = 1'b0;
         beat_idx = 0;
         tick(3);
      end

      // random blocks
      for (int t = 0; t < 25; t++) begin
         enable_block(int'($urandom % 24), int'($urandom % 6), int'($urandom % 6),
                      1'($urandom % 2));
         if (exp_rem == 0) begin
            tick(1);
            chk("R7 zero block done", int'(blk_done), 1);
         end else begin
            finish_block();
         end
      end

      // watermark request generator (R10, R11)
      chan_en = 1'b0;
      for (int t = 0; t < 40; t++) begin
         bit d;
         int lv, wm;
         d  = 1'(t % 2);
         lv = int'($urandom % 16);
         wm = (t < 4) ? lv : int'($urandom % 16);
         cfg_is_dst = d;
         per_fifo_level = LVL_W'(lv);
         per_fifo_wm = LVL_W'(wm);
         tick(1);
         if (d) chk("R11 dst request", int'(per_req_n), (lv < wm) ? 0 : 1);
         else   chk("R10 src request", int'(per_req_n), (lv > wm) ? 0 : 1);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule